// File: doc/BRIEF.md
# Serial Input Expander Reader

This controller reads a chain of external parallel-in, serial-out shift registers and turns the bit stream into bytes. A one-cycle start pulse begins a read. The controller first drops the load line to capture the external inputs and then raises it again. It then walks through the bits. For each bit it waits through a low clock phase, samples the serial data line, and only then raises the shift clock for one high phase.

The sampled bits enter each byte at the top while the byte rotates right. After eight bits, the first bit read therefore sits in bit 0. Bytes fill the output array in order, starting at the least significant byte. When the extra-bit option is built in, one more low phase follows the last clock pulse. At its end the data line is sampled once more without any further pulse, which captures the cascade input of the last register in the chain.

At the end of a read a one-cycle done pulse comes out together with the new result. The result then holds until the next read completes. Every clock phase, and the load pulse, lasts a number of system cycles set by a divider input.

Top module: `serial_expander_reader`

## Requirements
- R1: After reset, load_n is 1, sclk is 0, done is 0, and data_out and extra_out are all zeros.
- R2: A start pulse seen while idle drives load_n low for exactly half_period+1 cycles, and sclk stays 0 for as long as load_n is low.
- R3: From the rising edge of load_n until done, load_n stays 1, and sclk never rises while load_n is 0.
- R4: A read issues exactly 8*NUM_BYTES sclk pulses. Each high phase and each low phase lasts half_period+1 cycles, and a low phase precedes every pulse.
- R5: ser_in is sampled at the end of each low phase, before that bit's rising edge. The first bit of each byte ends in bit 0 and the eighth in bit 7, and byte k is placed at data_out[8k+7:8k], with k counting up in read order.
- R6: With EXTRA_BIT=1, one further low phase follows the last pulse. ser_in is sampled at its end into extra_out, with no extra sclk pulse. With EXTRA_BIT=0, extra_out stays 0.
- R7: done is high for one cycle per read. The period from the cycle after start was seen to done is (half_period+1)*(1+16*NUM_BYTES+EXTRA_BIT) cycles. data_out and extra_out change only in the cycle done is high.
- R8: A start pulse during a read is ignored: no second load, no extra pulses, and no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a read when idle |
| half_period | input | DIV_W | Phase length minus one, in system cycles |
| ser_in | input | 1 | Serial data from the end of the register chain |
| load_n | output | 1 | Active-low capture strobe to the external registers |
| sclk | output | 1 | Shift clock to the external registers |
| done | output | 1 | One-cycle pulse when a new result is ready |
| data_out | output | 8*NUM_BYTES | Assembled bytes, byte 0 in the low bits |
| extra_out | output | 1 | Trailing bit read without a clock pulse |

## Verification
The bench builds two instances, each driving its own behavioural model of an external register chain. One instance uses three bytes with the extra bit enabled, so slot ordering across byte boundaries and the pulseless trailing sample can both be observed. The other uses a single byte with the extra bit disabled, which covers the path where the read ends on a high phase and extra_out must stay 0. Both instances share random divider values, including zero (one-cycle phases) and the largest value of the 4-bit divider.

// File: rtl/serial_expander_reader.sv
module serial_expander_reader #(
  parameter int NUM_BYTES = 2,
  parameter int EXTRA_BIT = 1,
  parameter int DIV_W     = 8,
  localparam int BITS     = 8 * NUM_BYTES,
  localparam int CW       = $clog2(BITS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half_period,
  input  logic             ser_in,
  output logic             load_n,
  output logic             sclk,
  output logic             done,
  output logic [BITS-1:0]  data_out,
  output logic             extra_out
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_LOW, S_HIGH} st_t;

  st_t              st;
  logic [DIV_W-1:0] tmr;
  logic [CW-1:0]    cnt;
  logic [BITS-1:0]  asm_q;

  wire phase_end = (tmr == '0);
  wire last_bit  = (cnt == CW'(BITS - 1));
  wire more_bits = (cnt < CW'(BITS));
  wire [CW-4:0] slot = cnt[CW-1:3];

  assign load_n = (st != S_LOAD);
  assign sclk   = (st == S_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      cnt       <= '0;
      asm_q     <= '0;
      data_out  <= '0;
      extra_out <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE)
        tmr <= phase_end ? half_period : tmr - 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          tmr <= half_period;
          if (start) st <= S_LOAD;
        end
        S_LOAD:
          if (phase_end) st <= S_LOW;
        S_LOW:
          if (phase_end) begin
            if (more_bits) begin
              asm_q[8*slot +: 8] <= {ser_in, asm_q[8*slot+1 +: 7]};
              st <= S_HIGH;
            end else begin
              if (EXTRA_BIT != 0) extra_out <= ser_in;
              data_out <= asm_q;
              done     <= 1'b1;
              st       <= S_IDLE;
            end
          end
        S_HIGH:
          if (phase_end) begin
            cnt <= cnt + 1'b1;
            if (last_bit && EXTRA_BIT == 0) begin
              data_out <= asm_q;
              done     <= 1'b1;
              st       <= S_IDLE;
            end else begin
              st <= S_LOW;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_clk_low_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> !sclk);

  p_load_stays_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOW || st == S_HIGH) |=> load_n);

  p_rise_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> ($past(load_n) && !$past(sclk)));

  p_extra_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (EXTRA_BIT == 0) |-> !extra_out);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(data_out) && $stable(extra_out)));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == S_HIGH) |=> load_n);

endmodule

// File: tb/tb_serial_expander_reader.sv
module piso_model #(parameter int W = 8) (
  input  logic         load_n,
  input  logic         sclk,
  input  logic         tail,
  input  logic [W-1:0] par,
  output logic         q
);
  logic [W-1:0] sr = '0;
  always @(posedge sclk or negedge load_n)
    if (!load_n) sr <= par;
    else         sr <= {tail, sr[W-1:1]};
  assign q = sr[0];
endmodule

module tb_serial_expander_reader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] hp = 4'd0;
  logic tail = 1'b0;
  logic [23:0] par3 = '0;
  logic [7:0]  par1 = '0;

  logic ld3, sk3, dn3, ex3, q3;
  logic [23:0] do3;
  logic ld1, sk1, dn1, ex1, q1;
  logic [7:0] do1;

  int checks = 0, fails = 0;
  int cyc = 0;
  int load_cyc, hi_cyc, rise3, clk_in_load, done3, done_at3;
  int rise1, done1, done_at1;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_expander_reader #(.NUM_BYTES(3), .EXTRA_BIT(1), .DIV_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .half_period(hp), .ser_in(q3),
    .load_n(ld3), .sclk(sk3), .done(dn3), .data_out(do3), .extra_out(ex3));

  serial_expander_reader #(.NUM_BYTES(1), .EXTRA_BIT(0), .DIV_W(4)) dut_small (
    .clk(clk), .rst_n(rst_n), .start(start), .half_period(hp), .ser_in(q1),
    .load_n(ld1), .sclk(sk1), .done(dn1), .data_out(do1), .extra_out(ex1));

  piso_model #(24) m3 (.load_n(ld3), .sclk(sk3), .tail(tail), .par(par3), .q(q3));
  piso_model #(8)  m1 (.load_n(ld1), .sclk(sk1), .tail(tail), .par(par1), .q(q1));

  always @(negedge clk) begin
    if (!ld3) load_cyc++;
    if (sk3) hi_cyc++;
    if (dn3) begin done3++; done_at3 = cyc; end
    if (dn1) begin done1++; done_at1 = cyc; end
  end
  always @(posedge sk3) begin rise3++; if (!ld3) clk_in_load++; end
  always @(posedge sk1) rise1++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic run_read(input logic [3:0] h, input logic [23:0] p3,
                          input logic [7:0] p1, input logic t, input bit disturb);
    int st_at, wait_n, len3, len1;
    @(posedge clk); #1;
    hp = h; par3 = p3; par1 = p1; tail = t;
    load_cyc = 0; hi_cyc = 0; rise3 = 0; clk_in_load = 0; done3 = 0;
    rise1 = 0; done1 = 0;
    start = 1'b1; st_at = cyc;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (3 * (h + 1) + 2) @(posedge clk);
    #1;
    par3 = ~p3; par1 = ~p1;
    if (disturb) begin
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    wait_n = 0;
    while ((done3 == 0 || done1 == 0) && wait_n < 5000) begin
      @(posedge clk); wait_n++;
    end
    chk(wait_n < 5000, "R7 read completes", wait_n, 0);
    repeat (12) @(posedge clk);
    #1;
    len3 = (h + 1) * 50;
    len1 = (h + 1) * 17;
    chk(do3 == p3, "R5 byte order dut", do3, p3);
    chk(ex3 == t, "R6 extra bit dut", ex3, t);
    chk(do1 == p1, "R5 single byte", do1, p1);
    chk(ex1 == 1'b0, "R6 extra disabled", ex1, 0);
    chk(load_cyc == h + 1, "R2 load width", load_cyc, h + 1);
    chk(clk_in_load == 0, "R3 no rise in load", clk_in_load, 0);
    chk(rise3 == 24, "R4 pulse count dut", rise3, 24);
    chk(rise1 == 8, "R4 pulse count small", rise1, 8);
    chk(hi_cyc == 24 * (h + 1), "R4 high phase cycles", hi_cyc, 24 * (h + 1));
    chk(done3 == 1, "R7 R8 single done dut", done3, 1);
    chk(done1 == 1, "R7 R8 single done small", done1, 1);
    chk(done_at3 - st_at == len3 + 1, "R7 read length dut", done_at3 - st_at, len3 + 1);
    chk(done_at1 - st_at == len1 + 1, "R7 read length small", done_at1 - st_at, len1 + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ld3 == 1'b1 && ld1 == 1'b1, "R1 reset load_n", {ld3, ld1}, 2'b11);
    chk(sk3 == 1'b0 && sk1 == 1'b0, "R1 reset sclk", {sk3, sk1}, 0);
    chk(dn3 == 1'b0 && do3 == '0 && ex3 == 1'b0 && do1 == '0, "R1 reset outputs", do3, 0);
    rst_n = 1'b1;
    run_read(4'd0, 24'h000000, 8'h00, 1'b1, 1'b0);
    run_read(4'd0, 24'hFFFFFF, 8'hFF, 1'b0, 1'b1);
    run_read(4'd15, 24'hA5C381, 8'h01, 1'b1, 1'b1);
    run_read(4'd1, 24'h800001, 8'h80, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      run_read(4'($urandom_range(0, 5)), 24'($urandom), 8'($urandom),
               1'($urandom), 1'($urandom));
    end
    summary();
    $finish;
  end
endmodule